// File: doc/BRIEF.md
# SPI Command Stream CRC Checker

This block sits behind an SPI slave that hands over one 16-bit command frame at a time with a single-cycle valid strobe. It keeps a running 8-bit CRC over every accepted frame, folding in the upper (command) byte first and then the lower byte, each most significant bit first. The generator polynomial and the seed are module parameters.

A frame whose upper byte equals the check opcode is a check command. The lower byte of a check command is the CRC value that the host computed. Only the check command's own opcode byte is folded into the running value, and the result is then compared against the host's byte. A difference sets a sticky fault flag. Every check reseeds the accumulator, whether the compare passed or failed. Two control pulses complete the block. One clears the accumulator back to its seed. The other clears the fault flag.

Top module: `crc_stream_checker`

## Requirements
- R1: While and after reset, `crc_value` is the seed 0xFF and `spi_fault` is 0.
- R2: A frame accepted with an upper byte other than 0xFA updates `crc_value` on the next clock edge. The new value is the CRC of the upper byte followed by the lower byte. Bits enter most significant first, the polynomial is `POLY` (default 0x2F), and there is no reflection and no final XOR.
- R3: For an accepted frame with upper byte 0xFA (the check command), only that upper byte is folded into the running CRC. The result is compared with the frame's lower byte, and the lower byte itself never enters the CRC.
- R4: On the clock edge that follows any check command, `crc_value` returns to 0xFF, whether the compare matched or not.
- R5: A check whose lower byte differs from the computed value sets `spi_fault` one cycle later. A matching check leaves `spi_fault` unchanged.
- R6: `spi_fault` stays set until a `clr_fault` pulse clears it one cycle later. A mismatch in the same cycle as `clr_fault` wins, and the flag stays set.
- R7: A `clr_crc` pulse sets `crc_value` to 0xFF one cycle later. A frame presented in the same cycle is ignored: it causes no CRC update and no compare.
- R8: In a cycle with neither `frame_valid` nor `clr_crc`, `crc_value` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe marking a received frame |
| frame | input | 16 | Received frame, command byte in bits 15:8 |
| clr_crc | input | 1 | Reseeds the running CRC; a frame in the same cycle is dropped |
| clr_fault | input | 1 | Clears the sticky fault flag |
| crc_value | output | 8 | Current running CRC |
| spi_fault | output | 1 | Sticky CRC-mismatch flag |

## Verification
Every result of this block is registered. A frame, `clr_crc` or `clr_fault` presented before a rising edge appears on `crc_value` or `spi_fault` just after that same edge, one cycle of latency. The bench changes inputs on the falling edge, holds each strobe for exactly one rising edge, and samples both outputs on the next falling edge, so each check sees the edge it targets. The expected CRC comes from a bench-side bit-serial model with per-bit feedback, which the bench advances with the same byte rules as the requirements.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;

    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 2 * BYTE_W;
    localparam int CRC_W   = BYTE_W;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [CRC_W-1:0]   crc_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic {
        FK_DATA  = 1'b0,
        FK_CHECK = 1'b1
    } frame_kind_e;

    // Decoded frame carried from the decoder to the accumulator
    typedef struct packed {
        logic        take;   // frame accepted this cycle
        frame_kind_e kind;
        byte_t       op;     // upper byte, folded first
        byte_t       arg;    // lower byte
    } frame_dec_t;

    // Fold one byte into a CRC, MSB first, no reflection
    function automatic crc_t crc_fold_byte(crc_t acc, byte_t din, crc_t poly);
        crc_t r;
        r = acc ^ din;
        for (int b = 0; b < BYTE_W; b++) begin
            if (r[CRC_W-1]) r = (r << 1) ^ poly;
            else            r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/crcchk_decode.sv
module crcchk_decode
    import crcchk_pkg::*;
#(
    parameter byte_t CHECK_OP = 8'hFA
) (
    input  logic       frame_valid,
    input  frame_t     frame,
    input  logic       clr_crc,
    output frame_dec_t dec
);

    always_comb begin
        dec.op   = frame[FRAME_W-1:BYTE_W];
        dec.arg  = frame[BYTE_W-1:0];
        // clear has priority: a frame in a clear cycle is dropped (R7)
        dec.take = frame_valid && !clr_crc;
        dec.kind = (dec.op == CHECK_OP) ? FK_CHECK : FK_DATA;
    end

endmodule

// File: rtl/crcchk_accum.sv
module crcchk_accum
    import crcchk_pkg::*;
#(
    parameter crc_t POLY = 8'h2F,
    parameter crc_t SEED = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_crc,
    input  frame_dec_t dec,
    output crc_t       crc_q,
    output logic       mismatch
);

    crc_t after_op;
    crc_t after_arg;

    always_comb begin
        after_op  = crc_fold_byte(crc_q, dec.op, POLY);
        after_arg = crc_fold_byte(after_op, dec.arg, POLY);
        mismatch  = dec.take && (dec.kind == FK_CHECK) && (after_op != dec.arg);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_crc) begin
            crc_q <= SEED;
        end else if (dec.take) begin
            if (dec.kind == FK_CHECK) crc_q <= SEED;
            else                      crc_q <= after_arg;
        end
    end

    AST_CLEAR_RESEEDS: assert property (@(posedge clk) disable iff (rst)
        clr_crc |=> (crc_q == SEED)); // R7

    AST_CHECK_RESEEDS: assert property (@(posedge clk) disable iff (rst)
        (dec.take && dec.kind == FK_CHECK) |=> (crc_q == SEED)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!dec.take && !clr_crc) |=> $stable(crc_q)); // R8

    AST_NO_MISMATCH_ON_DATA: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == FK_DATA || !dec.take) |-> !mismatch); // R3

endmodule

// File: rtl/crcchk_fault.sv
module crcchk_fault (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic fault_q
);

    always_ff @(posedge clk) begin
        if (rst)        fault_q <= 1'b0;
        else if (set_i) fault_q <= 1'b1;   // a new mismatch wins over clear
        else if (clr_i) fault_q <= 1'b0;
    end

    AST_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
        set_i |=> fault_q); // R5

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fault_q && !clr_i) |=> fault_q); // R6

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q) |-> $past(set_i)); // R5

    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !fault_q); // R6

endmodule

// File: rtl/crc_stream_checker.sv
module crc_stream_checker
    import crcchk_pkg::*;
#(
    parameter crc_t  POLY     = 8'h2F,
    parameter crc_t  SEED     = 8'hFF,
    parameter byte_t CHECK_OP = 8'hFA
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame,
    input  logic               clr_crc,
    input  logic               clr_fault,
    output logic [CRC_W-1:0]   crc_value,
    output logic               spi_fault
);

    frame_dec_t dec;
    logic       mismatch;

    crcchk_decode #(.CHECK_OP(CHECK_OP)) u_decode (
        .frame_valid (frame_valid),
        .frame       (frame),
        .clr_crc     (clr_crc),
        .dec         (dec)
    );

    crcchk_accum #(.POLY(POLY), .SEED(SEED)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .clr_crc  (clr_crc),
        .dec      (dec),
        .crc_q    (crc_value),
        .mismatch (mismatch)
    );

    crcchk_fault u_fault (
        .clk     (clk),
        .rst     (rst),
        .set_i   (mismatch),
        .clr_i   (clr_fault),
        .fault_q (spi_fault)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (crc_value == SEED && !spi_fault)); // R1

endmodule

// File: tb/tb_crc_stream_checker.sv
module tb_crc_stream_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_valid = 1'b0;
    logic [15:0] frame = '0;
    logic        clr_crc = 1'b0;
    logic        clr_fault = 1'b0;
    logic [7:0]  crc_value;
    logic        spi_fault;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] model = 8'hFF;
    bit done = 0;

    always #10 clk = ~clk;

    crc_stream_checker dut (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame(frame),
        .clr_crc(clr_crc), .clr_fault(clr_fault),
        .crc_value(crc_value), .spi_fault(spi_fault)
    );

    // bit-serial reference with per-bit feedback, poly 0x2F
    function automatic logic [7:0] ref_step(logic [7:0] c, logic [7:0] d);
        logic [7:0] x = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = x[7] ^ d[i];
            x = {x[6:0], 1'b0};
            if (fb) x = x ^ 8'h2F;
        end
        return x;
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // one cycle of stimulus, then sample after the edge
    task automatic cyc(logic v, logic [15:0] f, logic cc, logic cf);
        frame_valid = v; frame = f; clr_crc = cc; clr_fault = cf;
        @(posedge clk);
        @(negedge clk);
        frame_valid = 0; clr_crc = 0; clr_fault = 0;
    endtask

    task automatic send_data(logic [15:0] f);
        cyc(1, f, 0, 0);
        model = ref_step(ref_step(model, f[15:8]), f[7:0]);
    endtask

    task automatic t_reset();
        chk("R1 crc after reset", crc_value, 8'hFF);
        chk("R1 fault after reset", {7'd0, spi_fault}, 8'd0);
    endtask

    task automatic t_single();
        send_data(16'h1234);
        chk("R2 single frame", crc_value, model);
        send_data(16'hFB2A);
        chk("R2 second frame", crc_value, model);
    endtask

    task automatic t_idle();
        repeat (3) @(negedge clk);
        chk("R8 idle hold", crc_value, model);
    endtask

    task automatic t_good_check();
        logic [7:0] e;
        cyc(0, 16'h0, 1, 0); model = 8'hFF;
        send_data(16'hFC00);
        send_data(16'hFB2A);
        send_data(16'hFC13);
        e = ref_step(model, 8'hFA);
        cyc(1, {8'hFA, e}, 0, 0); model = 8'hFF;
        chk("R3 matching check no fault", {7'd0, spi_fault}, 8'd0);
        chk("R4 reseed after good check", crc_value, 8'hFF);
    endtask

    task automatic t_bad_check();
        logic [7:0] e;
        send_data(16'h5A5A);
        e = ref_step(model, 8'hFA);
        cyc(1, {8'hFA, e ^ 8'h01}, 0, 0); model = 8'hFF;
        chk("R5 mismatch sets fault", {7'd0, spi_fault}, 8'd1);
        chk("R4 reseed after bad check", crc_value, 8'hFF);
    endtask

    task automatic t_sticky();
        logic [7:0] e;
        send_data(16'h0102);
        chk("R6 fault sticky over data", {7'd0, spi_fault}, 8'd1);
        e = ref_step(model, 8'hFA);
        cyc(1, {8'hFA, e}, 0, 0); model = 8'hFF;
        chk("R6 fault sticky over good check", {7'd0, spi_fault}, 8'd1);
        cyc(0, 16'h0, 0, 1);
        chk("R6 clr_fault clears", {7'd0, spi_fault}, 8'd0);
    endtask

    task automatic t_clr_crc();
        send_data(16'hC3E1);
        cyc(0, 16'h0, 1, 0); model = 8'hFF;
        chk("R7 clr_crc reseeds", crc_value, 8'hFF);
        cyc(1, 16'h7788, 1, 0);
        chk("R7 frame with clear dropped", crc_value, 8'hFF);
        cyc(1, 16'hFA00, 1, 0);
        chk("R7 check with clear no compare", {7'd0, spi_fault}, 8'd0);
        chk("R7 check with clear crc", crc_value, 8'hFF);
    endtask

    task automatic t_clear_vs_set();
        logic [7:0] e;
        e = ref_step(model, 8'hFA);
        cyc(1, {8'hFA, ~e}, 0, 1); model = 8'hFF;
        chk("R6 mismatch beats clr_fault", {7'd0, spi_fault}, 8'd1);
        cyc(0, 16'h0, 0, 1);
        chk("R6 final clear", {7'd0, spi_fault}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_reset();
        t_single();
        t_idle();
        t_good_check();
        t_bad_check();
        t_sticky();
        t_clr_crc();
        t_clear_vs_set();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule